// File: doc/BRIEF.md
# Ring interrupt status unit

This block gathers DMA ring events for a host interface with a configurable number of hops. Each hop contributes three event sources: a transmit ring, a receive ring and a receive-overflow condition. The block latches every event as a pending flag. It packs the flags into 32-bit status words that software reads over a simple word-addressed register bus. It raises a one-cycle interrupt pulse when something is pending.

Software selects one of two clearing disciplines through a control register. In the first, any status read wipes every pending flag. In the second, status reads leave the flags alone, and software clears individual flags by writing ones to a clear window. After each notification, the unit stays silent until software has read every status word at least once. Only then does it raise the next notification.

Top module: `ring_irq_status`

## Requirements
- R1: Flag index i is bit i%32 of status word i/32, at bus word index i/32. Transmit hop h uses i = h. Receive hop h uses i = HOP_COUNT + h. Overflow hop h uses i = 2*HOP_COUNT + h. Bits at or above 3*HOP_COUNT always read 0.
- R2: There are NW = (31 + 3*HOP_COUNT)/32 status words. A read of any word index that is neither a status word nor the control word returns 0.
- R3: The control register resets to 0, which leaves auto-clear off. With auto-clear off, status reads leave every flag unchanged.
- R4: The control register holds an auto-clear enable bit (bit 2). When auto-clear is in effect, a status read returns the word as it stood before the read, and it clears all flags in all words.
- R5: Bit 17 of the control register disables auto-clear. It wins over bit 2 when both are set.
- R6: A write to word index 2+k clears only the flags of status word k whose data bits are 1. This works in either mode. The clear word for receive rings therefore sits at index 2 + (HOP_COUNT+h)/32.
- R7: An event that arrives in the same cycle as a clearing write or a clearing read for the same flag leaves that flag set.
- R8: irq_o is a single-cycle pulse. It fires one cycle after a flag becomes pending while the unit is armed, and it disarms the unit.
- R9: A disarmed unit re-arms once every status word has been read at least once since the last pulse, in any order. A pending flag then yields a new pulse.
- R10: After reset, all flags are 0, the unit is armed, irq_o is 0 and bus_rvalid_o is 0.
- R11: The control word sits at index 2+NW. It reads back only bits 2 and 17. All other bits read 0.
- R12: Read data and bus_rvalid_o appear one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_evt_i | input | HOP_COUNT | Transmit ring event, one per hop |
| rx_evt_i | input | HOP_COUNT | Receive ring event, one per hop |
| ovf_evt_i | input | HOP_COUNT | Receive overflow event, one per hop |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Notification pulse |

## Verification
A corrupted flag shows up on the first read of its word. That read follows the event by one cycle, and its data arrives one cycle after the request. A flag that a clear should have removed, or that an event should have kept, shows on the next read. A wrong arm state shows within two cycles of the deciding event: either a missing pulse, a duplicate pulse, or a pulse that fires before every word has been read. The bench sweeps every flag index of a 12-hop configuration to catch these cases.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int unsigned CLR_BASE_IDX = 2;
  localparam int unsigned AUTO_BIT     = 2;
  localparam int unsigned DIS_BIT      = 17;

  function automatic int unsigned stat_words(int unsigned hops);
    return (31 + 3 * hops) / 32;
  endfunction
endpackage

// File: rtl/ring_flag_bank.sv
module ring_flag_bank #(
  parameter int unsigned NW = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NW-1:0][31:0]  evt_i,
  input  logic                 clr_all_i,
  input  logic                 clr_we_i,
  input  logic [NW-1:0]        clr_sel_i,
  input  logic [31:0]          clr_data_i,
  output logic [NW-1:0][31:0]  flags_o
);
  logic [31:0] kill [NW];

  for (genvar w = 0; w < NW; w++) begin : g_kill
    always_comb begin
      if (clr_all_i)                      kill[w] = '1;
      else if (clr_we_i && clr_sel_i[w])  kill[w] = clr_data_i;
      else                                kill[w] = '0;
    end
  end

  // events are OR'd after the clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else begin
      for (int w = 0; w < int'(NW); w++)
        flags_o[w] <= (flags_o[w] & ~kill[w]) | evt_i[w];
    end
  end

  a_r7_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));
  a_r3_hold_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_all_i && !clr_we_i) |=> (flags_o == ($past(flags_o) | $past(evt_i))));
  a_r4_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (flags_o == $past(evt_i)));
endmodule

// File: rtl/ring_rearm_ctl.sv
module ring_rearm_ctl #(
  parameter int unsigned NW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_i,
  input  logic [NW-1:0] rd_sel_i,
  output logic          irq_o
);
  logic          armed_q;
  logic [NW-1:0] seen_q;
  logic [NW-1:0] seen_nx;

  assign seen_nx = seen_q | rd_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      seen_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (armed_q) begin
        if (pend_i) begin
          irq_o   <= 1'b1;
          armed_q <= 1'b0;
          seen_q  <= '0;
        end
      end else if (&seen_nx) begin
        armed_q <= 1'b1;
        seen_q  <= '0;
      end else begin
        seen_q <= seen_nx;
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r9_pulse_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(armed_q));
endmodule

// File: rtl/ring_reg_if.sv
module ring_reg_if import ring_irq_pkg::*; #(
  parameter int unsigned NW     = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [NW-1:0][31:0]  flags_i,
  output logic [NW-1:0]        rd_sel_o,
  output logic                 clr_all_o,
  output logic                 clr_we_o,
  output logic [NW-1:0]        clr_sel_o,
  output logic [31:0]          clr_data_o,
  output logic [31:0]          rdata_o,
  output logic                 rvalid_o
);
  localparam int unsigned CTRL_IDX = CLR_BASE_IDX + NW;

  logic [31:0] a;
  logic        rd, wr;
  logic        auto_q, dis_q;
  logic [31:0] stat_word, ctrl_word;

  assign a  = 32'(addr_i);
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  for (genvar w = 0; w < NW; w++) begin : g_dec
    assign rd_sel_o[w]  = rd && (a == 32'(w));
    assign clr_sel_o[w] = (a == 32'(CLR_BASE_IDX + w));
  end

  assign clr_we_o   = wr && (|clr_sel_o);
  assign clr_data_o = wdata_i;
  assign clr_all_o  = (|rd_sel_o) && auto_q && !dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b0;
      dis_q  <= 1'b0;
    end else if (wr && a == 32'(CTRL_IDX)) begin
      auto_q <= wdata_i[AUTO_BIT];
      dis_q  <= wdata_i[DIS_BIT];
    end
  end

  always_comb begin
    stat_word = '0;
    for (int w = 0; w < int'(NW); w++)
      if (rd_sel_o[w]) stat_word = flags_i[w];
    ctrl_word = '0;
    ctrl_word[AUTO_BIT] = auto_q;
    ctrl_word[DIS_BIT]  = dis_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= (a == 32'(CTRL_IDX)) ? ctrl_word : stat_word;
    end
  end

  a_r5_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rd_sel_o) && dis_q) |-> !clr_all_o);
  a_r12_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
endmodule

// File: rtl/ring_irq_status.sv
module ring_irq_status import ring_irq_pkg::*; #(
  parameter int unsigned HOP_COUNT = 12,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [HOP_COUNT-1:0]  tx_evt_i,
  input  logic [HOP_COUNT-1:0]  rx_evt_i,
  input  logic [HOP_COUNT-1:0]  ovf_evt_i,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  output logic                  bus_rvalid_o,
  output logic                  irq_o
);
  localparam int unsigned NW    = stat_words(HOP_COUNT);
  localparam int unsigned NBITS = 3 * HOP_COUNT;

  logic [NW*32-1:0]     evt_flat;
  logic [NW-1:0][31:0]  evt_w, flags;
  logic [NW-1:0]        rd_sel, clr_sel;
  logic                 clr_all, clr_we;
  logic [31:0]          clr_data;

  // field order tx | rx | ovf from bit 0 upward
  always_comb begin
    evt_flat = '0;
    evt_flat[NBITS-1:0] = {ovf_evt_i, rx_evt_i, tx_evt_i};
  end
  assign evt_w = evt_flat;

  ring_reg_if #(.NW(NW), .ADDR_W(ADDR_W)) u_reg (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .flags_i(flags), .rd_sel_o(rd_sel), .clr_all_o(clr_all), .clr_we_o(clr_we),
    .clr_sel_o(clr_sel), .clr_data_o(clr_data),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  ring_flag_bank #(.NW(NW)) u_bank (
    .clk_i, .rst_ni, .evt_i(evt_w), .clr_all_i(clr_all), .clr_we_i(clr_we),
    .clr_sel_i(clr_sel), .clr_data_i(clr_data), .flags_o(flags)
  );

  ring_rearm_ctl #(.NW(NW)) u_arm (
    .clk_i, .rst_ni, .pend_i(|flags), .rd_sel_i(rd_sel), .irq_o
  );

  a_r1_no_pad_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags >> NBITS) == '0));
endmodule

// File: tb/sim_ring_irq_status.sv
`timescale 1ns/1ps
module sim_ring_irq_status;
  localparam int H  = 12;
  localparam int NW = (31 + 3 * H) / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [H-1:0] tx = '0, rx = '0, ovf = '0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rvalid, irq;
  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_irq_status #(.HOP_COUNT(H), .ADDR_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_evt_i(tx), .rx_evt_i(rx), .ovf_evt_i(ovf),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq));

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  task automatic set_bit(int i);
    if (i < H) tx[i] = 1'b1;
    else if (i < 2 * H) rx[i - H] = 1'b1;
    else ovf[i - 2 * H] = 1'b1;
  endtask

  task automatic drop_evt();
    tx = '0; rx = '0; ovf = '0;
  endtask

  task automatic pulse(int i);
    @(negedge clk); set_bit(i);
    @(negedge clk); drop_evt();
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 4'(a);
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush();
    logic [31:0] d;
    wr(2, '1); wr(3, '1); rd(0, d); rd(1, d); idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c0;
    idle(2); rst_n = 1'b1; idle(1);
    // R10 reset state
    chk("R10 irq", 32'(irq), 0);
    chk("R10 rvalid", 32'(rvalid), 0);
    rd(0, d); chk("R10 word0", d, 0);
    chk("R12 rvalid", 32'(rvalid), 1);
    rd(1, d); chk("R10 word1", d, 0);
    rd(4, d); chk("R3 ctrl reset", d, 0);
    idle(2); chk("R10 no irq", 32'(irq_cnt), 0);

    // R1/R2 all flags at once
    @(negedge clk); tx = '1; rx = '1; ovf = '1;
    @(negedge clk); drop_evt();
    rd(0, d); chk("R1 word0 full", d, 32'hFFFF_FFFF);
    rd(1, d); chk("R2 word1 pad", d, 32'h0000_000F);
    for (int a = 2; a < 16; a++)
      if (a != 4) begin rd(a, d); chk("R2 empty index", d, 0); end
    flush();

    // R1/R6/R8 sweep of every flag index
    for (int i = 0; i < 3 * H; i++) begin
      c0 = irq_cnt;
      pulse(i); idle(2);
      chk("R8 one pulse", 32'(irq_cnt), 32'(c0 + 1));
      rd(i / 32, d); chk("R1 position", d, 32'(1) << (i % 32));
      rd(i / 32, d); chk("R3 read keeps", d, 32'(1) << (i % 32));
      wr(2 + i / 32, 32'(1) << (i % 32));
      rd(0, d); chk("R6 cleared w0", d, 0);
      rd(1, d); chk("R6 cleared w1", d, 0);
      idle(2); chk("R8 no extra pulse", 32'(irq_cnt), 32'(c0 + 1));
    end

    // R6 selective clear
    pulse(0); pulse(5); pulse(7);
    wr(2, 32'h21);
    rd(0, d); chk("R6 partial", d, 32'h80);
    flush();

    // R9 re-arm needs every word read
    c0 = irq_cnt;
    pulse(0); idle(2); chk("R9 first pulse", 32'(irq_cnt), 32'(c0 + 1));
    pulse(1); idle(2); chk("R8 disarmed", 32'(irq_cnt), 32'(c0 + 1));
    rd(1, d); rd(1, d); idle(2); chk("R9 partial reads", 32'(irq_cnt), 32'(c0 + 1));
    rd(0, d); idle(2); chk("R9 rearmed pulse", 32'(irq_cnt), 32'(c0 + 2));
    flush();

    // R7 event vs clear write in same cycle
    pulse(9);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 4'd2; wdata = 32'h200; tx[9] = 1'b1;
    @(negedge clk); req = 1'b0; we = 1'b0; drop_evt();
    rd(0, d); chk("R7 w1c collision", d, 32'h200);
    flush();

    // R4 auto-clear
    wr(4, 32'h4);
    rd(4, d); chk("R11 ctrl auto", d, 32'h4);
    pulse(3); pulse(33);
    rd(0, d); chk("R4 pre-read value", d, 32'h8);
    rd(1, d); chk("R4 all cleared w1", d, 0);
    rd(0, d); chk("R4 all cleared w0", d, 0);
    // R7 event during clearing read
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 4'd1; tx[5] = 1'b1;
    @(negedge clk); req = 1'b0; drop_evt();
    rd(0, d); chk("R7 auto collision", d, 32'h20);
    rd(0, d); chk("R4 cleared after", d, 0);

    // R5 disable wins
    wr(4, 32'h0002_0004);
    pulse(2);
    rd(0, d); chk("R5 read 1", d, 32'h4);
    rd(0, d); chk("R5 read 2", d, 32'h4);
    rd(4, d); chk("R11 both bits", d, 32'h0002_0004);
    wr(4, 32'hFFFF_FFFF);
    rd(4, d); chk("R11 masked", d, 32'h0002_0004);
    wr(4, 32'h0);
    rd(4, d); chk("R3 ctrl off", d, 0);
    flush();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule